// File: doc/BRIEF.md
# Programmable chopper clock generator

This block derives two square-wave chopper clocks from one fast reference clock, which also serves as the block's system clock. A register elsewhere supplies a 2-bit code for the fast output and a 4-bit code for the slow output. Each code either holds its output high or selects a division ratio.

The fast output offers three rates: 512 kHz, 256 kHz and 16.384 MHz. The slow output offers seven rates. With a slow code value n between 1 and 7, the slow output runs at 1 kHz divided by 2·n, which covers 500 Hz down to about 71.4 Hz.

Each output comes from a counter of reference cycles that toggles the output when it reaches its terminal count, so every active output has a 50% duty cycle. Every output period begins with its low half. A new code is loaded only at the point where one period ends and the next begins. The one exception is when the output is held high: a running code then takes effect at once. As a result, a code change never cuts a pulse short. The reference frequency and the slow base unit are parameters, so the block can run at reduced ratios.

Top module: `chopclk_gen`

## Requirements
- R1: After reset, both outputs are high, and they stay high while their codes are zero.
- R2: With reference frequency F, a fast code of 1, 2 or 3 makes the fast output stay low for F/1,024,000, F/512,000 or F/32,768,000 reference cycles per period, and stay high for the same count.
- R3: Every active output has equal low and high times, which gives a 50% duty cycle.
- R4: With reference frequency F and slow unit U (1 kHz by default), a slow code n from 1 to 7 gives a slow output whose low and high halves each last F·n/U reference cycles.
- R5: Slow codes 8 to 15 act like code 0. An idle slow output stays high. A running slow output finishes its current period and then stays high.
- R6: When the code of a running output changes, the period in progress completes at the old length. The following period uses the new length.
- R7: When the code of a running output is set to zero, the output completes its current period and then stays high.
- R8: When an output held high is given a running code, the output goes low at the first reference edge that sees that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, which also clocks the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_sel | input | 2 | Rate code for the fast output (0 holds it high) |
| slow_sel | input | 4 | Rate code for the slow output (0 and 8 to 15 hold it high) |
| fast_chop_o | output | 1 | Fast chopper clock |
| slow_chop_o | output | 1 | Slow chopper clock |

## Verification
The hardest situation to reach is a code change in the middle of a period, because a correct design hides it completely until the period ends. The stimulus watches for a falling edge of the output and waits a fixed number of low cycles. It then changes the code between clock edges. It measures that low half and the high half that follows, and only then measures a fresh period. The same timing is used for changes into the held-high state and into a reserved slow code, so the bench can show that the period in progress keeps its full length.

// File: rtl/chopclk_pkg.sv
package chopclk_pkg;

  localparam longint FAST_HZ_C1 = 64'd512_000;
  localparam longint FAST_HZ_C2 = 64'd256_000;
  localparam longint FAST_HZ_C3 = 64'd16_384_000;
  localparam int     SLOW_MAX_N = 7;

  // Half-period, in reference cycles, for a fast code (0 = held high).
  function automatic longint fast_half(input logic [1:0] code, input longint ref_hz);
    longint h;
    case (code)
      2'd1:    h = ref_hz / (2 * FAST_HZ_C1);
      2'd2:    h = ref_hz / (2 * FAST_HZ_C2);
      2'd3:    h = ref_hz / (2 * FAST_HZ_C3);
      default: h = 0;
    endcase
    if (code != 2'd0 && h < 1) h = 1;
    return h;
  endfunction

  // Half-period for a slow code: output at unit/(2n) Hz -> half = ref*n/unit.
  function automatic longint slow_half(input logic [3:0] code, input longint ref_hz,
                                       input longint unit_hz);
    longint h;
    if (code >= 4'd1 && code <= 4'(SLOW_MAX_N)) begin
      h = (ref_hz * longint'(code)) / unit_hz;
      if (h < 1) h = 1;
    end else begin
      h = 0;
    end
    return h;
  endfunction

  function automatic longint max_half(input longint ref_hz, input longint unit_hz);
    longint m;
    m = 1;
    for (int c = 1; c < 4; c++)
      if (fast_half(2'(c), ref_hz) > m) m = fast_half(2'(c), ref_hz);
    for (int c = 1; c <= SLOW_MAX_N; c++)
      if (slow_half(4'(c), ref_hz, unit_hz) > m) m = slow_half(4'(c), ref_hz, unit_hz);
    return m;
  endfunction

endpackage

// File: rtl/chopclk_fast_dec.sv
module chopclk_fast_dec
  import chopclk_pkg::*;
#(
  parameter longint REF_HZ = 64'd32_768_000,
  parameter int     HALF_W = 18
) (
  input  logic [1:0]        sel_i,
  output logic              park_o,
  output logic [HALF_W-1:0] half_o
);
  longint h;
  always_comb begin
    h      = fast_half(sel_i, REF_HZ);
    park_o = (sel_i == 2'd0);
    half_o = HALF_W'(h);
  end
endmodule

// File: rtl/chopclk_slow_dec.sv
module chopclk_slow_dec
  import chopclk_pkg::*;
#(
  parameter longint REF_HZ  = 64'd32_768_000,
  parameter longint UNIT_HZ = 64'd1000,
  parameter int     HALF_W  = 18
) (
  input  logic [3:0]        sel_i,
  output logic              park_o,
  output logic [HALF_W-1:0] half_o
);
  longint h;
  always_comb begin
    h      = slow_half(sel_i, REF_HZ, UNIT_HZ);
    park_o = (h == 0);
    half_o = HALF_W'(h);
  end
endmodule

// File: rtl/chopclk_div.sv
module chopclk_div #(
  parameter int HALF_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_park_i,
  input  logic [HALF_W-1:0] req_half_i,
  output logic              chop_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] cur_half_q;
  logic              out_q;
  logic              parked_q;

  // Named events for checking
  logic tc_evt;      // terminal count of a half period
  logic period_end;  // end of high half: new code may be loaded
  logic wake_evt;    // leaving the held-high state

  assign tc_evt     = !parked_q && (cnt_q == cur_half_q - HALF_W'(1));
  assign period_end = tc_evt && out_q;
  assign wake_evt   = parked_q && !req_park_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q      <= 1'b1;
      parked_q   <= 1'b1;
      cnt_q      <= '0;
      cur_half_q <= HALF_W'(1);
    end else if (wake_evt) begin
      parked_q   <= 1'b0;
      cur_half_q <= req_half_i;
      cnt_q      <= '0;
      out_q      <= 1'b0;
    end else if (period_end) begin
      cnt_q <= '0;
      if (req_park_i) begin
        parked_q <= 1'b1;
        out_q    <= 1'b1;
      end else begin
        cur_half_q <= req_half_i;
        out_q      <= 1'b0;
      end
    end else if (tc_evt) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (!parked_q) begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  assign chop_o = out_q;

  AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    parked_q |-> chop_o) else $error("parked output not high"); // R1

  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !parked_q |-> (cur_half_q != '0)) else $error("zero half period"); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !parked_q |-> (cnt_q < cur_half_q)) else $error("counter overran half"); // R3

  AST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!parked_q && !period_end) |=> (cur_half_q == $past(cur_half_q))) else $error("half changed mid-period"); // R6

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_o != $past(chop_o)) |-> $past(tc_evt || wake_evt)) else $error("edge without terminal count"); // R6

  AST_PARK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(parked_q) && parked_q) |-> $past(period_end)) else $error("parked before period end"); // R7

  AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !chop_o) else $error("wake did not drive low"); // R8
endmodule

// File: rtl/chopclk_gen.sv
module chopclk_gen
  import chopclk_pkg::*;
#(
  parameter longint REF_HZ  = 64'd32_768_000,
  parameter longint UNIT_HZ = 64'd1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fast_sel,
  input  logic [3:0] slow_sel,
  output logic       fast_chop_o,
  output logic       slow_chop_o
);
  localparam longint MAX_H  = max_half(REF_HZ, UNIT_HZ);
  localparam int     HALF_W = $clog2(MAX_H + 1) + 1;

  logic              fast_park, slow_park;
  logic [HALF_W-1:0] fast_half_w, slow_half_w;

  chopclk_fast_dec #(.REF_HZ(REF_HZ), .HALF_W(HALF_W)) u_fast_dec (
    .sel_i(fast_sel), .park_o(fast_park), .half_o(fast_half_w));

  chopclk_slow_dec #(.REF_HZ(REF_HZ), .UNIT_HZ(UNIT_HZ), .HALF_W(HALF_W)) u_slow_dec (
    .sel_i(slow_sel), .park_o(slow_park), .half_o(slow_half_w));

  chopclk_div #(.HALF_W(HALF_W)) u_fast_div (
    .clk(clk), .rst_n(rst_n), .req_park_i(fast_park), .req_half_i(fast_half_w),
    .chop_o(fast_chop_o));

  chopclk_div #(.HALF_W(HALF_W)) u_slow_div (
    .clk(clk), .rst_n(rst_n), .req_park_i(slow_park), .req_half_i(slow_half_w),
    .chop_o(slow_chop_o));

  AST_RSV_SLOW_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sel >= 4'd8) |-> slow_park) else $error("reserved slow code not parked"); // R5
endmodule

// File: tb/chopclk_gen_tb.sv
module chopclk_gen_tb;
  localparam longint REF_HZ  = 64'd32_768_000;
  localparam longint UNIT_HZ = 64'd2_048_000;
  localparam int     CAP     = 400;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] fast_sel;
  logic [3:0] slow_sel;
  logic fast_chop_o, slow_chop_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  chopclk_gen #(.REF_HZ(REF_HZ), .UNIT_HZ(UNIT_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .slow_sel(slow_sel),
    .fast_chop_o(fast_chop_o), .slow_chop_o(slow_chop_o));

  function automatic int exp_fast(int c);
    longint f;
    f = (c == 1) ? 512_000 : (c == 2) ? 256_000 : 16_384_000;
    return int'(REF_HZ / (2 * f));
  endfunction

  function automatic int exp_slow(int n);
    return int'((REF_HZ * n) / UNIT_HZ);
  endfunction

  function automatic logic cur(int w);
    return (w == 0) ? fast_chop_o : slow_chop_o;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_sel(int w, int c);
    if (w == 0) fast_sel = 2'(c); else slow_sel = 4'(c);
  endtask

  task automatic wait_fall(int w);
    logic p, c;
    p = cur(w);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      c = cur(w);
      if (p && !c) return;
      p = c;
    end
  endtask

  // measure one period from its falling edge; optionally change code after chg_at low samples
  task automatic measure(int w, int chg_at, int chg_code, output int lo, output int hi);
    wait_fall(w);
    lo = 1;
    if (chg_at == 1) set_sel(w, chg_code);
    for (int i = 0; i < CAP; i++) begin
      @(negedge clk);
      if (cur(w) == 1'b0) begin
        lo++;
        if (lo == chg_at) set_sel(w, chg_code);
      end else break;
    end
    hi = 1;
    for (int i = 0; i < CAP; i++) begin
      @(negedge clk);
      if (cur(w) == 1'b1) hi++; else break;
    end
  endtask

  task automatic count_high(int w, int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cur(w)) highs++;
    end
  endtask

  initial begin
    int lo, hi, hs;
    rst_n = 1'b0; fast_sel = 2'd0; slow_sel = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 fast reset", int'(fast_chop_o), 1);
    chk("R1 slow reset", int'(slow_chop_o), 1);
    rst_n = 1'b1;
    count_high(0, 20, hs); chk("R1 fast idle", hs, 20);
    count_high(1, 20, hs); chk("R1 slow idle", hs, 20);

    // R8: leaving held-high drives low at first edge
    fast_sel = 2'd1;
    @(negedge clk); chk("R8 fast wake", int'(fast_chop_o), 0);

    for (int c = 1; c < 4; c++) begin
      fast_sel = 2'(c);
      measure(0, -1, 0, lo, hi);
      measure(0, -1, 0, lo, hi);
      chk($sformatf("R2 fast code %0d low", c), lo, exp_fast(c));
      chk($sformatf("R3 fast code %0d duty", c), hi, lo);
    end

    slow_sel = 4'd1;
    @(negedge clk); chk("R8 slow wake", int'(slow_chop_o), 0);
    for (int n = 1; n < 8; n++) begin
      slow_sel = 4'(n);
      measure(1, -1, 0, lo, hi);
      measure(1, -1, 0, lo, hi);
      chk($sformatf("R4 slow code %0d low", n), lo, exp_slow(n));
      chk($sformatf("R3 slow code %0d duty", n), hi, lo);
    end

    // R6: mid-period change completes old period
    fast_sel = 2'd2;
    measure(0, -1, 0, lo, hi);
    measure(0, 10, 1, lo, hi);
    chk("R6 old low kept", lo, exp_fast(2));
    chk("R6 old high kept", hi, exp_fast(2));
    measure(0, -1, 0, lo, hi);
    chk("R6 new period", lo, exp_fast(1));

    // R7: park at end of period
    measure(0, 5, 0, lo, hi);
    chk("R7 last low full", lo, exp_fast(1));
    chk("R7 then held high", hi, CAP + 1);

    // R5: reserved slow code from running and from idle
    slow_sel = 4'd7;
    measure(1, 3, 12, lo, hi);
    chk("R5 running low full", lo, exp_slow(7));
    count_high(1, 300, hs); chk("R5 held after rsv", hs, 300);
    slow_sel = 4'd9;
    count_high(1, 300, hs); chk("R5 idle rsv", hs, 300);
    slow_sel = 4'd15;
    count_high(1, 100, hs); chk("R5 idle rsv 15", hs, 100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule